// File: doc/BRIEF.md
# Vector String Isolate Unit

This unit takes a 128-bit operand and treats it as a string of equal-width elements (8, 16 or 32 bits). The first element sits at the most significant end, and the others follow toward bit 0. The unit looks for the first element whose bits are all zero, called the terminator. It clears the terminator and every element after it. Elements that come before the terminator are left as they are. Alongside the truncated vector, the unit reports a two-valued condition code that says whether a terminator was found.

A request is a one-cycle `start` pulse with the operand and the element size. The result, the condition code and an illegal-size flag are registered. They appear one cycle later, together with a one-cycle `result_valid` pulse. The result and the condition code then hold until the next request.

Top module: `vstr_isolate`

## Requirements
- R1: `esize` selects the element width: 0 gives 8 bits, 1 gives 16 bits and 2 gives 32 bits. Elements are aligned to their own width. Element 0 occupies the most significant bits, and a run of zero bytes that crosses an element boundary is not a zero element.
- R2: The terminator is the zero element nearest the most significant end. Zero elements at less significant positions do not move it.
- R3: The terminator and every less significant element are cleared to zero. Every more significant element appears in `result` unchanged.
- R4: When the terminator lies in bits 127:64, all of bits 63:0 of `result` are zero.
- R5: `cc` is 0 when a terminator was found and 3 when none was found. No other value appears while `result_valid` is high.
- R6: When no element is all-zero, `result` equals the operand.
- R7: When `esize` is 3, the response has `size_err` = 1, `result` = 0 and `cc` = 3. `size_err` is 1 only in the `result_valid` cycle of such a request.
- R8: A `start` sampled at a clock edge gives `result_valid` = 1 after that edge for exactly one cycle. `result_valid` is 0 in any cycle that does not follow a start.
- R9: After reset, `result_valid` = 0, `size_err` = 0, `result` = 0 and `cc` = 3.
- R10: When `start` is low, changes on `operand` and `esize` have no effect. `result` and `cc` keep the values of the last request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request strobe; operand and esize are sampled with it |
| esize | input | 2 | Element width select (0: 8, 1: 16, 2: 32, 3: illegal) |
| operand | input | 128 | Source vector, element 0 at bits 127 down |
| result_valid | output | 1 | One-cycle pulse marking a new response |
| result | output | 128 | Truncated vector |
| cc | output | 2 | Condition code: 0 terminator found, 3 none |
| size_err | output | 1 | Illegal element size flag for the current response |

## Verification
The main function is driven with the following patterns:
- **Random vectors with one injected zero element.** Every element is first forced nonzero. A single zero element is then placed at each position for each size, sometimes with a second zero placed further down. This separates the correct first-match choice from a choice of the last match, and tells apart clearing that starts at the terminator from clearing that starts one element early or late.
- **Directed vectors with zero bytes across an element boundary.** These give a cleared result at 8-bit width and an untouched result at 16-bit width, which exposes a width decode that looks at single bytes.
- **Fully nonzero and fully zero vectors.** These separate the pass-through case from a clear that starts at the top element.
- **A terminator at the last byte of the upper half.** This shows whether the whole lower half is cleared.
- **The illegal size and changes to the operand between requests.** These show whether the flag and the held outputs depend only on accepted requests.

// File: rtl/vstr_pkg.sv
package vstr_pkg;

    localparam int VEC_W   = 128;
    localparam int UNIT_W  = 8;
    localparam int N_SIZES = 3;
    localparam int SEL_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        ESZ_8   = 2'd0,
        ESZ_16  = 2'd1,
        ESZ_32  = 2'd2,
        ESZ_BAD = 2'd3
    } esize_e;

    typedef enum logic [1:0] {
        CC_TERM   = 2'd0,
        CC_NOTERM = 2'd3
    } ccode_e;

    typedef struct packed {
        ccode_e cc;
        logic   err;
    } iso_flags_t;

    function automatic logic size_legal(input logic [SEL_W-1:0] sel, input int n_sizes);
        return int'(sel) < n_sizes;
    endfunction

    function automatic ccode_e cc_of(input logic found);
        return found ? CC_TERM : CC_NOTERM;
    endfunction

endpackage

// File: rtl/vstr_zero_detect.sv
module vstr_zero_detect #(
    parameter int VEC_W   = vstr_pkg::VEC_W,
    parameter int UNIT_W  = vstr_pkg::UNIT_W,
    parameter int N_SIZES = vstr_pkg::N_SIZES,
    parameter int SEL_W   = vstr_pkg::SEL_W
) (
    input  logic [VEC_W-1:0]          vec,
    input  logic [SEL_W-1:0]          size_sel,
    output logic [VEC_W/UNIT_W-1:0]   term_unit
);
    localparam int N_UNITS = VEC_W / UNIT_W;

    logic [N_UNITS-1:0]              unit_zero;
    logic [N_SIZES-1:0][N_UNITS-1:0] lvl_zero;

    // one flag per smallest unit: all bits zero
    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        assign unit_zero[u] = ~|vec[u*UNIT_W +: UNIT_W];
    end

    // per size: a unit is marked when its whole aligned element is zero
    for (genvar s = 0; s < N_SIZES; s++) begin : g_size
        localparam int GRP = 1 << s;
        for (genvar u = 0; u < N_UNITS; u++) begin : g_lvl
            assign lvl_zero[s][u] = &unit_zero[(u / GRP) * GRP +: GRP];
        end
    end

    always_comb begin
        term_unit = '0;
        for (int s = 0; s < N_SIZES; s++) begin
            if (size_sel == SEL_W'(s)) term_unit = lvl_zero[s];
        end
    end

endmodule

// File: rtl/vstr_trunc_mask.sv
module vstr_trunc_mask #(
    parameter int N_UNITS = vstr_pkg::VEC_W / vstr_pkg::UNIT_W
) (
    input  logic [N_UNITS-1:0] term_unit,
    output logic [N_UNITS-1:0] clr_unit,
    output logic               found
);
    // a unit is cleared when it or any more significant unit is a terminator
    assign clr_unit[N_UNITS-1] = term_unit[N_UNITS-1];
    for (genvar u = N_UNITS - 2; u >= 0; u--) begin : g_chain
        assign clr_unit[u] = term_unit[u] | clr_unit[u+1];
    end

    assign found = clr_unit[0];

endmodule

// File: rtl/vstr_isolate.sv
module vstr_isolate
    import vstr_pkg::*;
#(
    parameter int VEC_W   = vstr_pkg::VEC_W,
    parameter int UNIT_W  = vstr_pkg::UNIT_W,
    parameter int N_SIZES = vstr_pkg::N_SIZES,
    parameter int SEL_W   = vstr_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [SEL_W-1:0] esize,
    input  logic [VEC_W-1:0] operand,
    output logic             result_valid,
    output logic [VEC_W-1:0] result,
    output logic [1:0]       cc,
    output logic             size_err
);
    localparam int N_UNITS = VEC_W / UNIT_W;

    logic [N_UNITS-1:0] term_unit;
    logic [N_UNITS-1:0] clr_unit;
    logic               found;
    logic               legal;
    logic [VEC_W-1:0]   nxt_data;
    iso_flags_t         nxt_flags;

    logic               valid_q;
    logic               err_q;
    logic [VEC_W-1:0]   data_q;
    ccode_e             cc_q;

    vstr_zero_detect #(
        .VEC_W   (VEC_W),
        .UNIT_W  (UNIT_W),
        .N_SIZES (N_SIZES),
        .SEL_W   (SEL_W)
    ) u_detect (
        .vec       (operand),
        .size_sel  (esize),
        .term_unit (term_unit)
    );

    vstr_trunc_mask #(
        .N_UNITS (N_UNITS)
    ) u_mask (
        .term_unit (term_unit),
        .clr_unit  (clr_unit),
        .found     (found)
    );

    assign legal = size_legal(esize, N_SIZES);

    for (genvar u = 0; u < N_UNITS; u++) begin : g_apply
        assign nxt_data[u*UNIT_W +: UNIT_W] =
            (clr_unit[u] || !legal) ? '0 : operand[u*UNIT_W +: UNIT_W];
    end

    always_comb begin
        nxt_flags.err = !legal;
        nxt_flags.cc  = legal ? cc_of(found) : CC_NOTERM;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            data_q  <= '0;
            cc_q    <= CC_NOTERM;
        end else begin
            valid_q <= start;
            err_q   <= start & nxt_flags.err;
            if (start) begin
                data_q <= nxt_data;
                cc_q   <= nxt_flags.cc;
            end
        end
    end

    assign result_valid = valid_q;
    assign result       = data_q;
    assign cc           = cc_q;
    assign size_err     = err_q;

    AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start |=> result_valid); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !start |=> !result_valid); // R8
    AST_CC_TWO_VALUES: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (cc == 2'd0 || cc == 2'd3)); // R5
    AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start |=> ((result & ~$past(operand)) == '0)); // R3
    AST_ERR_MATCHES_SIZE: assert property (@(posedge clk) disable iff (rst)
        start |=> (size_err == ($past(esize) == 2'd3))); // R7
    AST_HOLD_WITHOUT_START: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(result) && $stable(cc))); // R10
    AST_NOTERM_PASSES: assert property (@(posedge clk) disable iff (rst)
        (result_valid && cc == 2'd3 && !size_err) |-> (result == $past(operand))); // R6

endmodule

// File: tb/sim_vstr_isolate.sv
`timescale 1ns/1ps
module sim_vstr_isolate;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   esize = 2'd0;
    logic [127:0] operand = '0;
    logic         result_valid;
    logic [127:0] result;
    logic [1:0]   cc;
    logic         size_err;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vstr_isolate u0 (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .esize        (esize),
        .operand      (operand),
        .result_valid (result_valid),
        .result       (result),
        .cc           (cc),
        .size_err     (size_err)
    );

    function automatic logic [129:0] ref_iso(input logic [127:0] op, input logic [1:0] es);
        logic [127:0] r = op;
        logic [127:0] m;
        bit found = 0;
        int ew;
        if (es == 2'd3) return {2'd3, 128'd0};
        ew = 8 << es;
        m = (128'd1 << ew) - 128'd1;
        for (int e = 0; e < 128 / ew; e++) begin
            int lo = 128 - (e + 1) * ew;
            if (!found && (((op >> lo) & m) == 128'd0)) found = 1;
            if (found) r = r & ~(m << lo);
        end
        return {(found ? 2'd0 : 2'd3), r};
    endfunction

    function automatic logic [127:0] make_nonzero(input logic [127:0] v, input int es);
        int ew = 8 << es;
        logic [127:0] m = (128'd1 << ew) - 128'd1;
        for (int lo = 0; lo < 128; lo += ew) begin
            if (((v >> lo) & m) == 128'd0) v = v | (128'd1 << lo);
        end
        return v;
    endfunction

    function automatic logic [127:0] zero_elem(input logic [127:0] v, input int es, input int pos);
        int ew = 8 << es;
        logic [127:0] m = (128'd1 << ew) - 128'd1;
        return v & ~(m << (128 - (pos + 1) * ew));
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [127:0] op, input logic [1:0] es, input string req);
        logic [129:0] e = ref_iso(op, es);
        @(negedge clk);
        operand = op;
        esize   = es;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(result_valid == 1'b1, "R8", "valid pulse", 128'(result_valid), 128'd1);
        check(result == e[127:0], req, "result", result, e[127:0]);
        check(cc == e[129:128], "R5", "cc", 128'(cc), 128'(e[129:128]));
        check(size_err == (es == 2'd3), "R7", "size_err", 128'(size_err), 128'(es == 2'd3));
        operand = ~op;
        esize   = es ^ 2'd1;
        @(negedge clk);
        check(result_valid == 1'b0, "R8", "valid drop", 128'(result_valid), 128'd0);
        check(result == e[127:0], "R10", "held result", result, e[127:0]);
        check(cc == e[129:128], "R10", "held cc", 128'(cc), 128'(e[129:128]));
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [127:0] v;
        int unsigned seed_set;
        seed_set = $urandom(32'h5EED_1234);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check(result_valid == 1'b0, "R9", "valid", 128'(result_valid), 128'd0);
        check(size_err == 1'b0, "R9", "size_err", 128'(size_err), 128'd0);
        check(result == 128'd0, "R9", "result", result, 128'd0);
        check(cc == 2'd3, "R9", "cc", 128'(cc), 128'd3);

        // R1: zero bytes that do not form an aligned wider element
        v = 128'hFF00_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF;
        run(v, 2'd0, "R1");
        run(v, 2'd1, "R1");
        v = 128'hFF00_00FF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF;
        run(v, 2'd0, "R1");
        run(v, 2'd1, "R1");
        run(v, 2'd2, "R1");

        // R2: all-zero operand terminates at element 0
        for (int es = 0; es < 3; es++) run(128'd0, 2'(es), "R2");

        // R6: no zero element in any size
        for (int es = 0; es < 3; es++) begin
            for (int k = 0; k < 3; k++) run(make_nonzero(rnd128(), es), 2'(es), "R6");
        end

        // R4: terminator at the last byte of the upper half
        v = zero_elem(make_nonzero(rnd128(), 0), 0, 7);
        run(v, 2'd0, "R4");
        check(result[63:0] == 64'd0, "R4", "low half", 128'(result[63:0]), 128'd0);
        v = zero_elem(make_nonzero(rnd128(), 2), 2, 0);
        run(v, 2'd2, "R4");
        check(result[63:0] == 64'd0, "R4", "low half", 128'(result[63:0]), 128'd0);

        // R3 / R2: each position, each size, optional later zero
        for (int es = 0; es < 3; es++) begin
            for (int p = 0; p < (16 >> es); p++) begin
                v = zero_elem(make_nonzero(rnd128(), es), es, p);
                run(v, 2'(es), "R3");
                if (p + 1 < (16 >> es)) begin
                    v = zero_elem(v, es, p + 1 + int'($urandom_range(0, (16 >> es) - p - 2)));
                    run(v, 2'(es), "R2");
                end
            end
        end

        // R7: illegal size
        run(rnd128(), 2'd3, "R7");
        run(128'd0, 2'd3, "R7");
        run(make_nonzero(rnd128(), 0), 2'd0, "R7");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule